// File: doc/BRIEF.md
# Sequential Capture Trigger

This block decides the moment at which a logic analyzer begins to record. It watches a sample bus, 32 channels wide by default, that comes with a strobe marking the valid samples. It holds a short chain of trigger stages. Each stage compares the masked bits of a source word against a stored pattern. The source is either the present sample across all channels (parallel mode) or the last 32 bits seen on one chosen channel (serial mode). The stages must be satisfied in order, one per valid sample. When the last stage in the chain is satisfied, the block emits a one-cycle start pulse and raises a sticky running flag.

Software loads each stage through a small write port that has a stage index and a field selector. It then pulses the arm input. Arming returns the chain to its first stage, drops the running flag and empties the serial histories, so every hunt starts from a known state. Until the first arm after reset the block stays idle and ignores all samples.

Top module: `la_trigger_seq`

## Requirements
- R1: After reset, start_pulse and running are low, and no sample produces a start pulse until arm has been asserted once.
- R2: In parallel mode a stage is satisfied when every sample bit whose mask bit is 1 equals the corresponding bit of the stage's pattern.
- R3: Bits whose mask bit is 0 take no part in the comparison, so a stage whose mask is all zero is satisfied by the first valid sample it sees as the active stage.
- R4: Only the active stage is evaluated. A match on a stage that is not the last moves the chain to the next stage, and that next stage is first evaluated on the following valid sample. A single sample never satisfies two stages.
- R5: In serial mode each stage keeps a 32-bit history of its selected channel. On every valid sample the history shifts left and takes the new bit into bit 0. The comparison uses the history including the current sample.
- R6: Cycles with sample_valid low neither evaluate a stage nor shift any history.
- R7: A stage takes part only when its enable bit is set, and the first disabled stage ends the chain. If the stage at index 0 is disabled, start_pulse is high in the second cycle after the cycle in which arm is high.
- R8: When the last stage of the chain matches a valid sample, start_pulse is high for exactly the one cycle after that sample's clock edge and running becomes 1. running then stays 1 and no further pulse occurs until arm.
- R9: Arm resets the chain to stage 0, clears running and clears all serial histories, and it takes priority over a match in the same cycle.
- R10: A configuration write loads cfg_data into the stage given by cfg_stage. cfg_field 0 selects the mask, 1 the pattern and 2 the control word. In the control word, bit 0 is the enable, bit 1 selects serial mode, and bits 6:2 hold the serial channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Restart the stage chain and begin hunting |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 2 | Stage index for the write |
| cfg_field | input | 2 | Field selector: 0 mask, 1 pattern, 2 control |
| cfg_data | input | 32 | Write data |
| sample_valid | input | 1 | Marks a valid sample on sample_data |
| sample_data | input | 32 | Channel sample bus |
| start_pulse | output | 1 | One-cycle capture start |
| running | output | 1 | Sticky flag, set by the start and cleared by arm |

## Verification
The hardest case to reach is a serial match. It needs a history that was built over many valid samples, with invalid cycles interleaved that carry the opposite bit on the watched channel. A rearm also has to land in the middle of building that history, so the stale bits must not complete the pattern afterwards. The stimulus shifts an eight-bit pattern in from the oldest bit to the newest and puts a toggled, non-valid cycle between each pair of samples. A second pass arms just before the final bit. The chain is also driven with one sample value that would satisfy two adjacent stages at once, which shows that the pointer advances only one step per sample.

// File: rtl/la_trigger_seq.sv
module la_trigger_seq #(
  parameter int W      = 32,
  parameter int STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      arm,
  input  logic                      cfg_we,
  input  logic [$clog2(STAGES)-1:0] cfg_stage,
  input  logic [1:0]                cfg_field,
  input  logic [W-1:0]              cfg_data,
  input  logic                      sample_valid,
  input  logic [W-1:0]              sample_data,
  output logic                      start_pulse,
  output logic                      running
);
  localparam int CW = $clog2(W);
  localparam int SW = $clog2(STAGES);

  logic [W-1:0]      mask_q [STAGES];
  logic [W-1:0]      pat_q  [STAGES];
  logic [W-1:0]      hist_q [STAGES];
  logic [W-1:0]      hist_d [STAGES];
  logic [CW-1:0]     chan_q [STAGES];
  logic [STAGES-1:0] en_q, ser_q, hit;

  logic [SW-1:0] ptr_q, ptr_nx;
  logic          hunt_q, last, fire, adv;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    assign hist_d[g] = {hist_q[g][W-2:0], sample_data[chan_q[g]]};
    assign src       = ser_q[g] ? hist_d[g] : sample_data;
    assign hit[g]    = ((src ^ pat_q[g]) & mask_q[g]) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        mask_q[s] <= '0;
        pat_q[s]  <= '0;
        chan_q[s] <= '0;
        en_q[s]   <= 1'b0;
        ser_q[s]  <= 1'b0;
      end
    end else if (cfg_we) begin
      for (int s = 0; s < STAGES; s++) begin
        if (cfg_stage == SW'(s)) begin
          case (cfg_field)
            2'd0: mask_q[s] <= cfg_data;
            2'd1: pat_q[s]  <= cfg_data;
            2'd2: begin
              en_q[s]   <= cfg_data[0];
              ser_q[s]  <= cfg_data[1];
              chan_q[s] <= cfg_data[2 +: CW];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) hist_q[s] <= '0;
    end else if (arm) begin
      for (int s = 0; s < STAGES; s++) hist_q[s] <= '0;
    end else if (sample_valid) begin
      for (int s = 0; s < STAGES; s++) hist_q[s] <= hist_d[s];
    end
  end

  assign ptr_nx = ptr_q + SW'(1);
  assign last   = (ptr_q == SW'(STAGES - 1)) || !en_q[ptr_nx];
  assign fire   = hunt_q && !arm && (!en_q[ptr_q] || (sample_valid && hit[ptr_q] && last));
  assign adv    = hunt_q && !arm && en_q[ptr_q] && sample_valid && hit[ptr_q] && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      hunt_q      <= 1'b0;
      running     <= 1'b0;
      start_pulse <= 1'b0;
    end else if (arm) begin
      ptr_q       <= '0;
      hunt_q      <= 1'b1;
      running     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= fire;
      if (fire) begin
        hunt_q  <= 1'b0;
        running <= 1'b1;
      end
      if (adv) ptr_q <= ptr_nx;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    running && !arm |=> running);
  a_r8_rise_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> start_pulse);
  a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !running && !start_pulse && ptr_q == '0);
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (ptr_q == $past(ptr_q)) || (ptr_q == SW'($past(ptr_q) + SW'(1))));
  a_r6_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid && !arm |=> $stable(ptr_q) && $stable(hist_q[0]));
endmodule

// File: tb/test_la_trigger_seq.sv
`timescale 1ns/1ps
module test_la_trigger_seq;
  logic        clk = 0, rst_n = 0, arm = 0, cfg_we = 0, sample_valid = 0;
  logic [1:0]  cfg_stage = 0, cfg_field = 0;
  logic [31:0] cfg_data = 0, sample_data = 0;
  logic        start_pulse, running;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int exp_q[$];

  la_trigger_seq i_la_trigger_seq (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && start_pulse) begin
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R8 unexpected start_pulse at cycle %0d (expected none)", cyc);
    end else begin
      int e;
      e = exp_q.pop_front();
      if (e != cyc) begin
        n_bad++;
        $display("FAIL R8 start_pulse at cycle %0d, expected cycle %0d", cyc, e);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drain(string req);
    chk(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic cfg(int st, int fld, logic [31:0] d);
    cfg_we = 1; cfg_stage = 2'(st); cfg_field = 2'(fld); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_arm(bit expect_start);
    arm = 1;
    if (expect_start) exp_q.push_back(cyc + 2);
    @(negedge clk);
    arm = 0;
  endtask

  task automatic smp(logic [31:0] d, bit expect_start);
    sample_valid = 1; sample_data = d;
    if (expect_start) exp_q.push_back(cyc + 1);
    @(negedge clk);
    sample_valid = 0;
  endtask

  task automatic idle(int n, logic [31:0] d);
    sample_valid = 0; sample_data = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(bit b, bit expect_start);
    logic [31:0] base;
    base = 32'hDEAD_BEEF & ~32'h20;
    smp(base | (32'(b) << 5), expect_start);
    idle(1, base | (32'(!b) << 5));
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    pat = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 start after reset", start_pulse, 0);
    chk("R1 running after reset", running, 0);

    cfg(0, 0, 32'h0000_00FF); cfg(0, 1, 32'h0000_005A); cfg(0, 2, 32'h1);
    cfg(1, 2, 32'h0);
    smp(32'h0000_005A, 0); idle(2, 0);
    drain("R1 no start before arm");
    chk("R1 running before arm", running, 0);

    // R2 / R3: unmasked upper bits ignored
    do_arm(0);
    smp(32'hFFFF_FF5B, 0);
    smp(32'h0000_00DA, 0);
    smp(32'h1234_565A, 1);
    idle(1, 0);
    drain("R2 parallel masked match");
    chk("R8 running after start", running, 1);
    smp(32'h0000_005A, 0); idle(3, 0);
    drain("R8 no second pulse");
    chk("R8 running held", running, 1);

    // R4: four-stage chain, stages 1 and 2 share a pattern
    for (int s = 0; s < 4; s++) cfg(s, 0, 32'hFFFF_FFFF);
    cfg(0, 1, 32'hA); cfg(1, 1, 32'hB); cfg(2, 1, 32'hB); cfg(3, 1, 32'hD);
    for (int s = 0; s < 4; s++) cfg(s, 2, 32'h1);
    do_arm(0);
    chk("R9 running cleared by arm", running, 0);
    smp(32'hB, 0); smp(32'hA, 0); smp(32'hA, 0);
    smp(32'hB, 0); smp(32'hD, 0);
    smp(32'hB, 0); idle(3, 32'hD);
    drain("R4 no start before last stage");
    smp(32'hD, 1); idle(1, 0);
    drain("R4 last of four stages fires");

    // R5 / R6 / R10: serial on channel 5, mask FF, pattern A5
    cfg(0, 0, 32'hFF); cfg(0, 1, 32'hA5); cfg(0, 2, 32'h17);
    cfg(1, 2, 32'h0);
    do_arm(0);
    for (int i = 7; i >= 0; i--) ser_bit(pat[i], i == 0);
    drain("R5 serial history match");
    chk("R5 running after serial", running, 1);

    // R9: rearm wipes history
    do_arm(0);
    for (int i = 7; i >= 1; i--) ser_bit(pat[i], 0);
    do_arm(0);
    ser_bit(pat[0], 0); idle(2, 0);
    drain("R9 history cleared by arm");
    chk("R9 running stays low", running, 0);

    // R7: stage 0 disabled
    cfg(0, 2, 32'h0);
    do_arm(1);
    idle(2, 0);
    drain("R7 disabled stage 0 starts on arm");
    chk("R7 running", running, 1);

    // R3: all-zero mask stage
    cfg(0, 0, 32'hFF); cfg(0, 1, 32'h33); cfg(0, 2, 32'h1);
    cfg(1, 0, 32'h0); cfg(1, 2, 32'h1); cfg(2, 2, 32'h0);
    do_arm(0);
    smp(32'h0, 0); smp(32'h33, 0); smp(32'h0, 1); idle(1, 0);
    drain("R3 zero-mask stage matches first sample");

    // R9: rearm mid-chain returns to stage 0
    do_arm(0);
    smp(32'h33, 0);
    do_arm(0);
    smp(32'h0, 0); idle(2, 0);
    drain("R9 pointer reset by arm");
    smp(32'h33, 0); smp(32'h77, 1); idle(1, 0);
    drain("R4 chain after rearm");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule